// File: doc/BRIEF.md
# DSP Address Generation Unit

This unit computes data-memory addresses for a signal-processing datapath. It holds a bank of eight pointer registers, a step register and a buffer-length register. Pointer zero doubles as the index operand for the indexed modes. On an access cycle the unit drives the current value of the selected pointer on its address output. At the next clock edge it writes back that pointer after a post-modification chosen by an opcode. The access is therefore post-modify: the memory sees the address as it was before the update.

The modifications cover several cases. Plain pointer arithmetic steps by one or adds the step register. Circular stepping wraps inside a power-of-two buffer: only the low k bits move, and the bits above them keep the buffer's base. Bit-reversed stepping adds or subtracts the index with the carry running from the most significant bit down, which walks an FFT data array in reversed order. Two further opcodes present the step register itself as the address, one of them bumping it by one. Loads into any register arrive on a separate port in the same cycle as an access. A load beats a post-modify that targets the same register.

Top module: `dsp_agu`

## Requirements
- R1: While reset is asserted every pointer, the step register and the buffer length read as zero; reset is applied at once and released two clock edges after `rst_n` rises.
- R2: With `acc_en` high, `addr_out` shows the selected register's value before the modification, and the modified value is held from the next clock edge; only the selected pointer changes.
- R3: Opcodes 1, 2 and 3 post-modify the selected pointer by +1, -1 and +step, all modulo 2^AW.
- R4: Opcodes 4 and 5 post-modify by +1 and -1 inside a circular buffer of 2^k words, k being the buffer length: the low k bits wrap modulo 2^k and the upper bits stay unchanged.
- R5: Opcodes 6 and 7 do the same circular wrap while adding or subtracting the value of pointer 0.
- R6: A buffer length of 0, or of AW or more, makes the circular opcodes act as plain modulo-2^AW arithmetic.
- R7: Opcodes 8 and 9 add or subtract pointer 0 with reversed carry: result = rev(rev(A) ± rev(P0)), with rev mirroring all AW bits.
- R8: Opcode 10 drives the step register on `addr_out` and then increments it by one; opcode 11 drives the step register and leaves it unchanged.
- R9: Opcodes 0 and 12 to 15, and any opcode with `acc_en` low, change no register.
- R10: A load has priority over a post-modify of the same register in the same cycle; a load to a different register and a modify proceed together.
- R11: `ld_kind` 0 writes pointer `ld_sel`, 1 writes the step register, 2 writes the buffer length from the low KW bits of `ld_data`, and 3 writes nothing; the value is held from the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Access this cycle; enables the post-modify |
| acc_op | input | 4 | Post-modify opcode |
| acc_sel | input | 3 | Pointer selected for the access |
| ld_en | input | 1 | Load request |
| ld_kind | input | 2 | Load target: 0 pointer, 1 step, 2 buffer length, 3 none |
| ld_sel | input | 3 | Pointer written by a pointer load |
| ld_data | input | 16 | Load value |
| addr_out | output | 16 | Address before the post-modify |

## Verification
The properties assume that the bench changes inputs only away from the clock edge. They also assume that the synchronised reset has settled before any load or access. The checks for modify results leave out cycles in which a load hits the same register, because a separate property covers load priority. The stimulus waits out the reset release. It draws buffer lengths from 0 to 18, so it covers the wrap, no-wrap and oversize cases. It uses only opcodes and load kinds that the requirements define, plus the undefined opcodes that must do nothing.

// File: rtl/dsp_agu_pkg.sv
`timescale 1ns/1ps
package dsp_agu_pkg;

  typedef enum logic [3:0] {
    OP_HOLD  = 4'd0,
    OP_INC   = 4'd1,
    OP_DEC   = 4'd2,
    OP_ADDS  = 4'd3,
    OP_CINC  = 4'd4,
    OP_CDEC  = 4'd5,
    OP_CADDX = 4'd6,
    OP_CSUBX = 4'd7,
    OP_BADDX = 4'd8,
    OP_BSUBX = 4'd9,
    OP_SINC  = 4'd10,
    OP_SRD   = 4'd11
  } agu_op_e;

  typedef enum logic [1:0] {
    LD_AR   = 2'd0,
    LD_STEP = 2'd1,
    LD_BUFK = 2'd2,
    LD_NONE = 2'd3
  } agu_ld_e;

endpackage

// File: rtl/dsp_agu_arbank.sv
`timescale 1ns/1ps
module dsp_agu_arbank #(
  parameter int AW   = 16,
  parameter int NREG = 8,
  localparam int SW  = $clog2(NREG)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mod_we,
  input  logic [SW-1:0]        mod_sel,
  input  logic [AW-1:0]        mod_data,
  input  logic                 ld_we,
  input  logic [SW-1:0]        ld_sel,
  input  logic [AW-1:0]        ld_data,
  input  logic [SW-1:0]        rd_sel,
  output logic [AW-1:0]        rd_data,
  output logic [AW-1:0]        idx_data,
  output logic [NREG*AW-1:0]   ar_flat
);

  for (genvar gi = 0; gi < NREG; gi++) begin : g_ent
    logic          hit_ld;
    logic          hit_mod;
    logic          ent_en;
    logic [AW-1:0] ent_d;
    logic [AW-1:0] ent_q;

    // next state: a load to this entry outranks a modify of it
    always_comb begin
      hit_ld  = ld_we  && (ld_sel  == SW'(gi));
      hit_mod = mod_we && (mod_sel == SW'(gi));
      ent_en  = hit_ld || hit_mod;
      ent_d   = hit_ld ? ld_data : mod_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q <= '0;
      end else if (ent_en) begin
        ent_q <= ent_d;
      end
    end

    assign ar_flat[gi*AW +: AW] = ent_q;
  end

  always_comb begin
    rd_data  = ar_flat[int'(rd_sel)*AW +: AW];
    idx_data = ar_flat[AW-1:0];
  end

endmodule

// File: rtl/dsp_agu_modalu.sv
`timescale 1ns/1ps
module dsp_agu_modalu
  import dsp_agu_pkg::*;
#(
  parameter int AW = 16,
  localparam int KW = $clog2(AW+1)
) (
  input  logic [3:0]    op,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] idx,
  input  logic [AW-1:0] step,
  input  logic [KW-1:0] bufk,
  output logic [AW-1:0] nxt,
  output logic          wr
);

  logic [AW-1:0] kmask;
  logic [AW-1:0] cmask;
  logic [AW-1:0] rbase, ridx;
  logic [AW-1:0] rsum, rdif;
  logic [AW-1:0] bsum, bdif;

  // per-bit mask: bit i is inside the buffer when i < k
  for (genvar gi = 0; gi < AW; gi++) begin : g_mask
    assign kmask[gi] = (bufk > KW'(gi));
  end

  // mirrored operands and mirrored-back results for reversed carry
  for (genvar gi = 0; gi < AW; gi++) begin : g_rev
    assign rbase[gi] = base[AW-1-gi];
    assign ridx[gi]  = idx[AW-1-gi];
    assign bsum[gi]  = rsum[AW-1-gi];
    assign bdif[gi]  = rdif[AW-1-gi];
  end

  always_comb begin
    rsum = rbase + ridx;
    rdif = rbase - ridx;
  end

  // k = 0 means no wrapping: the whole word moves
  assign cmask = (bufk == '0) ? {AW{1'b1}} : kmask;

  function automatic logic [AW-1:0] wrap(input logic [AW-1:0] a,
                                         input logic [AW-1:0] s,
                                         input logic [AW-1:0] m);
    return (a & ~m) | (s & m);
  endfunction

  always_comb begin
    nxt = base;
    wr  = 1'b1;
    case (op)
      OP_INC:   nxt = base + 1'b1;
      OP_DEC:   nxt = base - 1'b1;
      OP_ADDS:  nxt = base + step;
      OP_CINC:  nxt = wrap(base, base + 1'b1, cmask);
      OP_CDEC:  nxt = wrap(base, base - 1'b1, cmask);
      OP_CADDX: nxt = wrap(base, base + idx, cmask);
      OP_CSUBX: nxt = wrap(base, base - idx, cmask);
      OP_BADDX: nxt = bsum;
      OP_BSUBX: nxt = bdif;
      default:  wr  = 1'b0;
    endcase
  end

endmodule

// File: rtl/dsp_agu.sv
`timescale 1ns/1ps
module dsp_agu
  import dsp_agu_pkg::*;
#(
  parameter int AW   = 16,
  parameter int NREG = 8,
  localparam int SW  = $clog2(NREG),
  localparam int KW  = $clog2(AW+1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_en,
  input  logic [3:0]    acc_op,
  input  logic [SW-1:0] acc_sel,
  input  logic          ld_en,
  input  logic [1:0]    ld_kind,
  input  logic [SW-1:0] ld_sel,
  input  logic [AW-1:0] ld_data,
  output logic [AW-1:0] addr_out
);

  // reset: asserted at once, released after two edges
  logic rst_m, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  logic [AW-1:0]      rd_ar;
  logic [AW-1:0]      idx_ar;
  logic [NREG*AW-1:0] ar_flat;
  logic [AW-1:0]      alu_nxt;
  logic               alu_wr;
  logic [AW-1:0]      step_q, step_d;
  logic               step_en;
  logic [KW-1:0]      bufk_q, bufk_d;
  logic               bufk_en;
  logic               ld_ar, ld_step, ld_bufk;
  logic               step_op;

  always_comb begin
    ld_ar   = ld_en && (ld_kind == LD_AR);
    ld_step = ld_en && (ld_kind == LD_STEP);
    ld_bufk = ld_en && (ld_kind == LD_BUFK);
    step_op = (acc_op == OP_SINC) || (acc_op == OP_SRD);
  end

  dsp_agu_modalu #(.AW(AW)) u_alu (
    .op   (acc_op),
    .base (rd_ar),
    .idx  (idx_ar),
    .step (step_q),
    .bufk (bufk_q),
    .nxt  (alu_nxt),
    .wr   (alu_wr)
  );

  dsp_agu_arbank #(.AW(AW), .NREG(NREG)) u_bank (
    .clk      (clk),
    .rst_n    (rst_s),
    .mod_we   (acc_en && alu_wr),
    .mod_sel  (acc_sel),
    .mod_data (alu_nxt),
    .ld_we    (ld_ar),
    .ld_sel   (ld_sel),
    .ld_data  (ld_data),
    .rd_sel   (acc_sel),
    .rd_data  (rd_ar),
    .idx_data (idx_ar),
    .ar_flat  (ar_flat)
  );

  // step register: load first, then the increment opcode
  always_comb begin
    step_en = ld_step || (acc_en && (acc_op == OP_SINC));
    step_d  = ld_step ? ld_data : step_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      step_q <= '0;
    end else if (step_en) begin
      step_q <= step_d;
    end
  end

  // buffer length register
  always_comb begin
    bufk_en = ld_bufk;
    bufk_d  = ld_data[KW-1:0];
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      bufk_q <= '0;
    end else if (bufk_en) begin
      bufk_q <= bufk_d;
    end
  end

  assign addr_out = step_op ? step_q : rd_ar;

endmodule

// File: rtl/dsp_agu_chk.sv
`timescale 1ns/1ps
module dsp_agu_chk
  import dsp_agu_pkg::*;
#(
  parameter int AW   = 16,
  parameter int NREG = 8,
  localparam int SW  = $clog2(NREG),
  localparam int KW  = $clog2(AW+1)
) (
  input logic               clk,
  input logic               rst_s,
  input logic               acc_en,
  input logic [3:0]         acc_op,
  input logic [SW-1:0]      acc_sel,
  input logic               ld_en,
  input logic [1:0]         ld_kind,
  input logic [SW-1:0]      ld_sel,
  input logic [AW-1:0]      ld_data,
  input logic [AW-1:0]      addr_out,
  input logic [NREG*AW-1:0] ar_flat,
  input logic [AW-1:0]      step_q,
  input logic [KW-1:0]      bufk_q
);

  logic [AW-1:0] arv [NREG];
  logic [AW-1:0] outer;
  logic          self_ld;

  for (genvar gi = 0; gi < NREG; gi++) begin : g_view
    assign arv[gi] = ar_flat[gi*AW +: AW];
  end

  // bits above the buffer; none when k = 0
  for (genvar gi = 0; gi < AW; gi++) begin : g_out
    assign outer[gi] = (bufk_q != '0) && (bufk_q <= KW'(gi));
  end

  assign self_ld = ld_en && (ld_kind == LD_AR) && (ld_sel == acc_sel);

  // R2
  inc_after_read_chk: assert property (@(posedge clk) disable iff (!rst_s)
    acc_en && (acc_op == OP_INC) && !self_ld
    |=> arv[$past(acc_sel)] == $past(addr_out) + 1'b1);

  // R4
  circ_upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_s)
    acc_en && ((acc_op == OP_CINC) || (acc_op == OP_CDEC)) && !self_ld
    |=> ((arv[$past(acc_sel)] ^ $past(addr_out)) & $past(outer)) == '0);

  // R9
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_s)
    !acc_en && !ld_en |=> $stable(ar_flat) && $stable(step_q) && $stable(bufk_q));

  // R10
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_s)
    ld_en && (ld_kind == LD_AR) |=> arv[$past(ld_sel)] == $past(ld_data));

  // R8
  step_inc_chk: assert property (@(posedge clk) disable iff (!rst_s)
    acc_en && (acc_op == OP_SINC) && !(ld_en && (ld_kind == LD_STEP))
    |=> step_q == $past(addr_out) + 1'b1);

  // R11
  bufk_load_chk: assert property (@(posedge clk) disable iff (!rst_s)
    ld_en && (ld_kind == LD_BUFK) |=> bufk_q == $past(ld_data[KW-1:0]));

endmodule

bind dsp_agu dsp_agu_chk #(.AW(AW), .NREG(NREG)) u_chk (
  .clk      (clk),
  .rst_s    (rst_s),
  .acc_en   (acc_en),
  .acc_op   (acc_op),
  .acc_sel  (acc_sel),
  .ld_en    (ld_en),
  .ld_kind  (ld_kind),
  .ld_sel   (ld_sel),
  .ld_data  (ld_data),
  .addr_out (addr_out),
  .ar_flat  (ar_flat),
  .step_q   (step_q),
  .bufk_q   (bufk_q)
);

// File: tb/sim_dsp_agu.sv
`timescale 1ns/1ps
module sim_dsp_agu;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_en;
  logic [3:0]  acc_op;
  logic [2:0]  acc_sel;
  logic        ld_en;
  logic [1:0]  ld_kind;
  logic [2:0]  ld_sel;
  logic [15:0] ld_data;
  logic [15:0] addr_out;

  int total = 0;
  int bad   = 0;

  logic [15:0] ar_m [8];
  logic [15:0] s_m;
  logic [4:0]  k_m;
  logic [15:0] last;

  always #2.5 clk = ~clk;

  dsp_agu u0 (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_op(acc_op),
    .acc_sel(acc_sel), .ld_en(ld_en), .ld_kind(ld_kind), .ld_sel(ld_sel),
    .ld_data(ld_data), .addr_out(addr_out)
  );

  task automatic chk(input logic [15:0] got, input logic [15:0] exp, input string req);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [15:0] rev16(input logic [15:0] v);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[i] = v[15-i];
    return r;
  endfunction

  function automatic logic [15:0] circ(input logic [15:0] a, input int d, input logic [4:0] k);
    int m, lo, hi;
    m  = (k == 0 || k >= 16) ? 65536 : (1 << k);
    lo = int'(a) % m;
    hi = int'(a) - lo;
    lo = ((lo + d) % m + m) % m;
    return 16'(hi + lo);
  endfunction

  function automatic logic [15:0] f_next(input logic [3:0] op, input logic [15:0] a,
                                         input logic [15:0] x, input logic [15:0] s,
                                         input logic [4:0] k);
    case (op)
      4'd1:    return a + 16'd1;
      4'd2:    return a - 16'd1;
      4'd3:    return a + s;
      4'd4:    return circ(a, 1, k);
      4'd5:    return circ(a, -1, k);
      4'd6:    return circ(a, int'(x), k);
      4'd7:    return circ(a, -int'(x), k);
      4'd8:    return rev16(rev16(a) + rev16(x));
      4'd9:    return rev16(rev16(a) - rev16(x));
      default: return a;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'd1, 4'd2, 4'd3:   return "R3";
      4'd4, 4'd5:         return "R4";
      4'd6, 4'd7:         return "R5";
      4'd8, 4'd9:         return "R7";
      4'd10, 4'd11:       return "R8";
      default:            return "R9";
    endcase
  endfunction

  // one access cycle: drive at negedge, compare pre-modify address, update model
  task automatic cyc(input bit en, input logic [3:0] op, input logic [2:0] sel,
                     input bit le, input logic [1:0] lk, input logic [2:0] ls,
                     input logic [15:0] ld);
    logic [15:0] exp, nx;
    @(negedge clk);
    acc_en = en; acc_op = op; acc_sel = sel;
    ld_en = le; ld_kind = lk; ld_sel = ls; ld_data = ld;
    #1;
    exp  = (op == 4'd10 || op == 4'd11) ? s_m : ar_m[sel];
    last = addr_out;
    chk(last, exp, tag_of(op));
    nx = f_next(op, ar_m[sel], ar_m[0], s_m, k_m);
    @(posedge clk);
    if (en && op >= 4'd1 && op <= 4'd9) ar_m[sel] = nx;
    if (en && op == 4'd10) s_m = s_m + 16'd1;
    if (le && lk == 2'd0) ar_m[ls] = ld;
    if (le && lk == 2'd1) s_m = ld;
    if (le && lk == 2'd2) k_m = ld[4:0];
  endtask

  task automatic ldr(input logic [1:0] lk, input logic [2:0] ls, input logic [15:0] v);
    cyc(0, 4'd0, 3'd0, 1, lk, ls, v);
  endtask

  task automatic peek(input logic [2:0] sel);
    cyc(0, 4'd0, sel, 0, 2'd3, 3'd0, 16'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd5173));
    rst_n = 1'b0; acc_en = 0; acc_op = 0; acc_sel = 0;
    ld_en = 0; ld_kind = 0; ld_sel = 0; ld_data = 0;
    for (int i = 0; i < 8; i++) ar_m[i] = 16'd0;
    s_m = 16'd0; k_m = 5'd0;
    repeat (3) @(posedge clk);
    // R1: reset state seen at the ports
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); acc_sel = 3'(i); #1;
      chk(addr_out, 16'd0, "R1");
    end
    @(negedge clk); acc_op = 4'd11; #1;
    chk(addr_out, 16'd0, "R1");
    acc_op = 4'd0;
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R11 / R2 / R3
    ldr(2'd0, 3'd3, 16'h1234);
    cyc(1, 4'd1, 3'd3, 0, 2'd3, 0, 0);
    chk(last, 16'h1234, "R2");
    peek(3); chk(last, 16'h1235, "R3");
    peek(2); chk(last, 16'h0000, "R2");
    cyc(1, 4'd2, 3'd2, 0, 2'd3, 0, 0);
    peek(2); chk(last, 16'hFFFF, "R3");

    // R4 circular +/-1 in 16-word buffer
    ldr(2'd2, 0, 16'd4);
    ldr(2'd0, 3'd1, 16'h00AF);
    cyc(1, 4'd4, 3'd1, 0, 2'd3, 0, 0);
    peek(1); chk(last, 16'h00A0, "R4");
    cyc(1, 4'd5, 3'd1, 0, 2'd3, 0, 0);
    peek(1); chk(last, 16'h00AF, "R4");

    // R5 circular by pointer 0
    ldr(2'd2, 0, 16'd3);
    ldr(2'd0, 3'd0, 16'd3);
    ldr(2'd0, 3'd2, 16'h0106);
    cyc(1, 4'd6, 3'd2, 0, 2'd3, 0, 0);
    peek(2); chk(last, 16'h0101, "R5");
    cyc(1, 4'd7, 3'd2, 0, 2'd3, 0, 0);
    peek(2); chk(last, 16'h0106, "R5");

    // R6 k = 0 and k >= AW act linearly
    ldr(2'd2, 0, 16'd0);
    ldr(2'd0, 3'd4, 16'h0FFF);
    cyc(1, 4'd4, 3'd4, 0, 2'd3, 0, 0);
    peek(4); chk(last, 16'h1000, "R6");
    ldr(2'd2, 0, 16'd18);
    ldr(2'd0, 3'd4, 16'hFFFF);
    cyc(1, 4'd4, 3'd4, 0, 2'd3, 0, 0);
    peek(4); chk(last, 16'h0000, "R6");

    // R7 reversed-carry walk
    ldr(2'd0, 3'd0, 16'h8000);
    ldr(2'd0, 3'd5, 16'h0000);
    cyc(1, 4'd8, 3'd5, 0, 2'd3, 0, 0); chk(last, 16'h0000, "R7");
    cyc(1, 4'd8, 3'd5, 0, 2'd3, 0, 0); chk(last, 16'h8000, "R7");
    cyc(1, 4'd8, 3'd5, 0, 2'd3, 0, 0); chk(last, 16'h4000, "R7");
    cyc(1, 4'd9, 3'd5, 0, 2'd3, 0, 0); chk(last, 16'hC000, "R7");
    peek(5); chk(last, 16'h4000, "R7");

    // R8 step register, R3 add-step
    ldr(2'd1, 0, 16'd5);
    ldr(2'd0, 3'd6, 16'd10);
    cyc(1, 4'd3, 3'd6, 0, 2'd3, 0, 0);
    peek(6); chk(last, 16'd15, "R3");
    cyc(1, 4'd10, 3'd6, 0, 2'd3, 0, 0); chk(last, 16'd5, "R8");
    cyc(1, 4'd11, 3'd6, 0, 2'd3, 0, 0); chk(last, 16'd6, "R8");
    peek(6); chk(last, 16'd15, "R8");

    // R9 hold, undefined opcode, disabled access
    cyc(1, 4'd0, 3'd6, 0, 2'd3, 0, 0);
    cyc(1, 4'd15, 3'd6, 0, 2'd3, 0, 0);
    cyc(0, 4'd1, 3'd6, 0, 2'd3, 0, 0);
    peek(6); chk(last, 16'd15, "R9");

    // R10 load beats modify on same register; other register proceeds
    cyc(1, 4'd1, 3'd7, 1, 2'd0, 3'd7, 16'h0055);
    peek(7); chk(last, 16'h0055, "R10");
    cyc(1, 4'd1, 3'd7, 1, 2'd0, 3'd6, 16'h0077);
    peek(7); chk(last, 16'h0056, "R10");
    peek(6); chk(last, 16'h0077, "R10");
    cyc(1, 4'd10, 3'd0, 1, 2'd1, 0, 16'h0100);
    cyc(0, 4'd11, 3'd0, 0, 2'd3, 0, 0); chk(last, 16'h0100, "R10");
    cyc(0, 4'd0, 3'd1, 1, 2'd3, 3'd1, 16'hDEAD);
    peek(1); chk(last, 16'h00AF, "R11");

    // random mix, every cycle checked against the model
    for (int n = 0; n < 4000; n++) begin
      logic [1:0]  lk;
      logic [15:0] lv;
      lk = 2'($urandom_range(0, 3));
      lv = (lk == 2'd2) ? 16'($urandom_range(0, 18)) : 16'($urandom);
      cyc(($urandom_range(0, 7) != 0), 4'($urandom), 3'($urandom),
          ($urandom_range(0, 4) == 0), lk, 3'($urandom), lv);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule